// File: doc/BRIEF.md
# Interrupt-Gated Bus Grant Arbiter

This block decides which of four bus masters owns a shared system bus: a CPU, a DMA engine, a USB host controller and an Ethernet MAC. Arbitration uses a fixed priority among masters that are allowed to request. It has a lockout feature that depends on the processor's two interrupt lines, the normal interrupt (IRQ) and the fast interrupt (FIQ). Five separately enabled pairings link one master to one interrupt line. While an enabled pairing's interrupt is high, that master loses any grant it holds and its requests are not considered. This keeps bus bandwidth free for interrupt service code.

The enable bits sit in a small register that can only be written. No read path exists, and the bits show their effect only through the grants. The grant output is a registered one-hot vector. The CPU is the default owner whenever no other master makes a valid request. IRQ and FIQ are treated as levels that are already synchronous to the bus clock.

Top module: `irq_gated_arbiter`

## Requirements
- R1: `gnt` is always one-hot, with bit 0 for the CPU, bit 1 for DMA, bit 2 for the USB host and bit 3 for the MAC. During reset and in the first cycle after reset, `gnt` equals 4'b0001 (CPU).
- R2: The enable register resets to all zeros. After reset, IRQ and FIQ have no effect on any grant.
- R3: Among requesting, unlocked masters, the grant goes in priority order DMA, then MAC, then USB host, then CPU.
- R4: When no unlocked master requests, the CPU is granted on the next edge, whether or not the CPU itself requests.
- R5: A master keeps its grant while it still requests and `xfer_done` is low, even when a higher-priority master requests. When the holder drops its request or `xfer_done` is high, arbitration runs again.
- R6: A master is locked while an enabled pairing of that master is active. On the next edge, a locked grant holder loses the grant, and the bus goes in that same edge to the highest-priority unlocked requester (or to the CPU if there is none).
- R7: A locked master's request is ignored: it is never granted while the lock holds.
- R8: When the paired interrupt goes low, the master's request is accepted again on the next edge.
- R9: Locking one master does not change the grants of the other masters. For example, a USB/IRQ lock leaves the MAC grantable while IRQ is high.
- R10: A write with `cfg_we` high loads `cfg_wdata` into the enable register at the edge. The lock takes effect for the next edge's arbitration. Bit layout: bit0 = DMA/FIQ, bit1 = USB/IRQ, bit2 = USB/FIQ, bit3 = MAC/IRQ, bit4 = MAC/FIQ.
- R11: The CPU is never locked. With all enables set and both interrupts high, a CPU request is still granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request per master (bit0 CPU, bit1 DMA, bit2 USB, bit3 MAC) |
| irq | input | 1 | Normal interrupt level, already synchronous |
| fiq | input | 1 | Fast interrupt level, already synchronous |
| xfer_done | input | 1 | Current holder finishes its transfer this cycle |
| cfg_we | input | 1 | Write strobe for the lock enable register |
| cfg_wdata | input | 5 | Lock enable bits to write |
| gnt | output | 4 | One-hot registered grant |

## Verification
The hardest case to reach is a lock that hits a master while it holds a grant and a lower-priority master is waiting. This has to land exactly one edge after the enable write becomes visible, with the interrupt raised while the holder keeps requesting. Directed sequences first put DMA or the MAC on the bus and write the enable bits. They then raise the matching interrupt and check that the waiting master takes over on the following edge. Long random runs with skewed interrupt and write rates then mix locks, releases and done pulses, and every cycle is compared against a bench model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int NUM_M    = 4;
    localparam int NUM_PAIR = 5;
    localparam int IDX_W    = $clog2(NUM_M);

    typedef enum logic [IDX_W-1:0] {
        M_CPU = 2'd0,
        M_DMA = 2'd1,
        M_USB = 2'd2,
        M_MAC = 2'd3
    } master_e;

    // last member is bit 0
    typedef struct packed {
        logic mac_fiq;
        logic mac_irq;
        logic usb_fiq;
        logic usb_irq;
        logic dma_fiq;
    } lock_en_t;

    typedef logic [NUM_M-1:0] mvec_t;

    // highest priority first
    localparam master_e PRIO_ORDER [NUM_M] = '{M_DMA, M_MAC, M_USB, M_CPU};

    function automatic mvec_t pick_winner(input mvec_t eligible);
        mvec_t w;
        w = '0;
        for (int k = NUM_M - 1; k >= 0; k--) begin
            if (eligible[PRIO_ORDER[k]]) begin
                w = '0;
                w[PRIO_ORDER[k]] = 1'b1;
            end
        end
        if (w == '0) w[M_CPU] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/arb_lock_reg.sv
module arb_lock_reg
    import irq_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [NUM_PAIR-1:0] wdata,
    output lock_en_t            en_q
);
    always_ff @(posedge clk) begin
        if (rst)     en_q <= '0;
        else if (we) en_q <= lock_en_t'(wdata);
    end
endmodule

// File: rtl/arb_lockout.sv
module arb_lockout
    import irq_arb_pkg::*;
(
    input  lock_en_t en,
    input  logic     irq,
    input  logic     fiq,
    output mvec_t    locked
);
    always_comb begin
        locked        = '0;
        locked[M_DMA] = en.dma_fiq & fiq;
        locked[M_USB] = (en.usb_irq & irq) | (en.usb_fiq & fiq);
        locked[M_MAC] = (en.mac_irq & irq) | (en.mac_fiq & fiq);
    end
endmodule

// File: rtl/arb_grant_core.sv
module arb_grant_core
    import irq_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mvec_t eligible,
    input  logic  done,
    output mvec_t gnt_q
);
    mvec_t gnt_d;
    logic  holder_keeps;

    assign holder_keeps = (|(gnt_q & eligible)) & ~done;

    always_comb begin
        if (holder_keeps) gnt_d = gnt_q;
        else              gnt_d = pick_winner(eligible);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q        <= '0;
            gnt_q[M_CPU] <= 1'b1;
        end else begin
            gnt_q <= gnt_d;
        end
    end
endmodule

// File: rtl/irq_gated_arbiter.sv
module irq_gated_arbiter
    import irq_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_M-1:0]    req,
    input  logic                irq,
    input  logic                fiq,
    input  logic                xfer_done,
    input  logic                cfg_we,
    input  logic [NUM_PAIR-1:0] cfg_wdata,
    output logic [NUM_M-1:0]    gnt
);
    lock_en_t en_q;
    mvec_t    locked;
    mvec_t    eligible;
    mvec_t    gnt_q;

    arb_lock_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .en_q  (en_q)
    );

    arb_lockout u_lock (
        .en     (en_q),
        .irq    (irq),
        .fiq    (fiq),
        .locked (locked)
    );

    assign eligible = req & ~locked;

    arb_grant_core u_core (
        .clk      (clk),
        .rst      (rst),
        .eligible (eligible),
        .done     (xfer_done),
        .gnt_q    (gnt_q)
    );

    assign gnt = gnt_q;
endmodule

// File: rtl/irq_gated_arbiter_chk.sv
module irq_gated_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NUM_M-1:0] req,
    input logic             xfer_done,
    input logic [NUM_M-1:0] locked,
    input logic [NUM_M-1:0] gnt
);
    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt) == 1);

    // R4
    idle_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        ((req & ~locked) == '0) |=> gnt[M_CPU]);

    // R11
    cpu_never_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !locked[M_CPU]);

    for (genvar m = 0; m < NUM_M; m++) begin : g_m
        // R7
        locked_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
            locked[m] |=> !gnt[m]);
        // R5
        hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
            (gnt[m] && req[m] && !locked[m] && !xfer_done) |=> gnt[m]);
    end
endmodule

bind irq_gated_arbiter irq_gated_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .xfer_done (xfer_done),
    .locked    (locked),
    .gnt       (gnt)
);

// File: tb/irq_gated_arbiter_tb.sv
module irq_gated_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic       irq = 1'b0;
    logic       fiq = 1'b0;
    logic       xfer_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [3:0] gnt;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] m_g;
    logic [4:0] m_en;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_gated_arbiter u_dut (
        .clk(clk), .rst(rst), .req(req), .irq(irq), .fiq(fiq),
        .xfer_done(xfer_done), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .gnt(gnt)
    );

    // bit0 CPU, bit1 DMA, bit2 USB, bit3 MAC
    function automatic logic [3:0] blocked_of(logic [4:0] en, logic i, logic f);
        logic [3:0] b;
        b    = 4'b0000;
        b[1] = en[0] && f;
        b[2] = (en[1] && i) || (en[2] && f);
        b[3] = (en[3] && i) || (en[4] && f);
        return b;
    endfunction

    function automatic logic [3:0] model_next(logic [3:0] g, logic [3:0] r,
                                              logic [4:0] en, logic i, logic f, logic d);
        logic [3:0] ok;
        ok = r & ~blocked_of(en, i, f);
        if (!d && (g & ok) != 4'b0000) return g;
        if (ok[1]) return 4'b0010;
        if (ok[3]) return 4'b1000;
        if (ok[2]) return 4'b0100;
        return 4'b0001;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge; drives, advances one cycle, checks at next negedge
    task automatic step(string tag, logic [3:0] r, logic i, logic f, logic d,
                        logic w, logic [4:0] wd);
        logic [3:0] ng;
        logic [4:0] ne;
        req = r; irq = i; fiq = f; xfer_done = d; cfg_we = w; cfg_wdata = wd;
        ng = model_next(m_g, r, m_en, i, f, d);
        ne = w ? wd : m_en;
        @(negedge clk);
        m_g  = ng;
        m_en = ne;
        check(tag, gnt, m_g);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: timeout actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 during reset", gnt, 4'b0001);
        rst = 1'b0;
        m_g = 4'b0001; m_en = 5'b0;
        @(negedge clk);
        check("R1 after reset", gnt, 4'b0001);

        // R2: no masking after reset
        step("R2", 4'b1110, 1, 1, 0, 0, 0);
        check("R2 dma granted with irq/fiq high", gnt, 4'b0010);
        step("R2", 4'b1100, 1, 1, 1, 0, 0);
        check("R2 mac granted with irq/fiq high", gnt, 4'b1000);

        // R4: idle -> CPU
        step("R4", 4'b0000, 0, 0, 0, 0, 0);
        check("R4 idle to cpu", gnt, 4'b0001);

        // R3: priority
        step("R3", 4'b1101, 0, 0, 1, 0, 0);
        check("R3 mac over usb/cpu", gnt, 4'b1000);
        step("R3", 4'b0101, 0, 0, 1, 0, 0);
        check("R3 usb over cpu", gnt, 4'b0100);

        // R5: usb holds while dma waits, then done
        step("R5", 4'b0110, 0, 0, 0, 0, 0);
        check("R5 usb holds", gnt, 4'b0100);
        step("R5", 4'b0110, 0, 0, 1, 0, 0);
        check("R5 done releases to dma", gnt, 4'b0010);

        // R10 + R6: enable DMA/FIQ, DMA holding, FIQ rises -> MAC
        step("R10", 4'b1010, 0, 0, 0, 1, 5'b00001);
        check("R10 write, dma still holds", gnt, 4'b0010);
        step("R6", 4'b1010, 0, 1, 0, 0, 0);
        check("R6 dma degranted, mac takes bus", gnt, 4'b1000);
        // R7: dma ignored while fiq high
        step("R7", 4'b0010, 0, 1, 0, 0, 0);
        check("R7 locked dma ignored", gnt, 4'b0001);
        step("R7", 4'b0010, 0, 1, 0, 0, 0);
        check("R7 locked dma still ignored", gnt, 4'b0001);
        // R8
        step("R8", 4'b0010, 0, 0, 0, 0, 0);
        check("R8 dma accepted after fiq low", gnt, 4'b0010);

        // R9: USB/IRQ lock leaves MAC grantable
        step("R9", 4'b0000, 0, 0, 0, 1, 5'b00010);
        step("R9", 4'b1100, 1, 0, 0, 0, 0);
        check("R9 mac granted under usb lock", gnt, 4'b1000);
        step("R9", 4'b0100, 1, 0, 0, 0, 0);
        check("R9 usb locked goes to cpu", gnt, 4'b0001);
        step("R9", 4'b0100, 0, 0, 0, 0, 0);
        check("R9 usb back after irq low", gnt, 4'b0100);

        // R11: CPU never locked
        step("R11", 4'b0000, 0, 0, 1, 1, 5'b11111);
        step("R11", 4'b1111, 1, 1, 1, 0, 0);
        check("R11 only cpu unlocked", gnt, 4'b0001);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] r;
            logic i, f, d, w;
            logic [4:0] wd;
            r  = 4'($urandom);
            i  = ($urandom % 3) == 0;
            f  = ($urandom % 4) == 0;
            d  = ($urandom % 5) == 0;
            w  = ($urandom % 16) == 0;
            wd = 5'($urandom);
            step("R6", r, i, f, d, w, wd);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule